// File: doc/BRIEF.md
# Key-Unlocked Flash Program/Erase Controller

This block sits between a register bus and a small on-chip flash array and carries out two destructive operations: programming a single 32-bit word and erasing a whole page. Software loads a target byte address and a data word, picks an operation code and sets a write-enable bit. It then writes a three-value key sequence and finally sets the start bit. The controller holds the start bit high as a busy flag for a configurable number of cycles, applies the operation to the array and drops the flag. Software polls for that drop.

Each register can be written in three forms: raw, bit-set and bit-clear. Single bits can therefore be changed without a read-modify-write. Pages can be protected by a per-page lock input. An operation aimed at a protected page leaves the array untouched and raises a sticky error flag. Only a completed no-operation start clears that flag. A behavioural array model is part of the block and has a read port, so results can be checked.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the control, address and data registers read 0, the key register reads 0, busy_o is low and every array word reads 0xFFFFFFFF.
- R2: reg_sel_i picks control (0), key (1), address (2) or data (3). reg_acc_i picks the write form: raw (0) stores the write data, set (1) ORs it into the register, clear (2) removes its ones from the register, and 3 leaves the register unchanged.
- R3: A start is honoured only when the last three key writes were 0x00000000, 0xAA996655 and 0x556699AA, in that order. Any other key value breaks the sequence. A zero value always restarts it, and a broken sequence makes a start request do nothing.
- R4: The control register has the operation code in bits 3:0, a low-voltage error flag in bit 12 (always 0), the write-error flag in bit 13, write enable in bit 14 and start/busy in bit 15. A start request whose resulting write-enable bit is 0 is ignored, and bit 15 stays 0.
- R5: Any control-register write consumes a completed unlock, whether or not it requests a start.
- R6: Operation code 1 ANDs the data register into the word at address bits above bit 1. busy_o stays high for PROG_CYCLES cycles.
- R7: Operation code 4 sets every word of the page holding the address to 0xFFFFFFFF and leaves other pages alone. busy_o stays high for ERASE_CYCLES cycles.
- R8: A program or erase aimed at a page whose page_lock_i bit is 1 still runs its busy time. It leaves the array unchanged and sets control bit 13.
- R9: Control bit 13 is not writable by software. A start with any code other than 1 or 4 is busy for one cycle and clears bit 13.
- R10: The hardware clears bit 15 when the operation ends. Control-register writes while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register selected for the write |
| reg_acc_i | input | 2 | Write form: raw, set, clear, none |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_sel_i | input | 2 | Register selected for reading |
| reg_rdata_o | output | 32 | Read data of the selected register |
| page_lock_i | input | NUM_PAGES | Per-page protection |
| arr_word_i | input | WORD_AW | Array word index for reading |
| arr_rdata_o | output | 32 | Array word contents |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with 4 pages of 4 words, a 3-cycle program time and a 7-cycle erase time. With these values a single run can reach every page, set up locked and unlocked neighbours, and count each busy window exactly. Word and page boundaries fall on small byte addresses, so erasing one page can be checked against programmed words on both sides of it. The short busy times leave room to fire control writes inside a running erase.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_KEY = 2'd1, SEL_ADDR = 2'd2, SEL_DATA = 2'd3} reg_sel_e;
  typedef enum logic [1:0] {ACC_RAW = 2'd0, ACC_SET = 2'd1, ACC_CLR = 2'd2, ACC_NONE = 2'd3} reg_acc_e;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_PROG  = 4'd1;
  localparam logic [3:0] OP_ERASE = 4'd4;

  localparam int unsigned B_BUSY  = 15;
  localparam int unsigned B_WREN  = 14;
  localparam int unsigned B_WRERR = 13;
  localparam int unsigned B_LVERR = 12;

  localparam logic [31:0] KEY_0 = 32'h0000_0000;
  localparam logic [31:0] KEY_1 = 32'hAA99_6655;
  localparam logic [31:0] KEY_2 = 32'h5566_99AA;

  function automatic logic [31:0] acc_apply(input logic [1:0] acc, input logic [31:0] cur,
                                            input logic [31:0] wd);
    case (acc)
      ACC_RAW: acc_apply = wd;
      ACC_SET: acc_apply = cur | wd;
      ACC_CLR: acc_apply = cur & ~wd;
      default: acc_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
  import flash_pe_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic [31:0] key_val_i,
  input  logic        consume_i,
  output logic        unlocked_o
);
  typedef enum logic [1:0] {K_IDLE, K_GOT0, K_GOT1, K_OPEN} key_st_e;
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (consume_i) st_d = K_IDLE;
    else if (key_wr_i) begin
      if (key_val_i == KEY_0)                        st_d = K_GOT0;
      else if (st_q == K_GOT0 && key_val_i == KEY_1) st_d = K_GOT1;
      else if (st_q == K_GOT1 && key_val_i == KEY_2) st_d = K_OPEN;
      else                                           st_d = K_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= K_IDLE;
    else         st_q <= st_d;

  assign unlocked_o = (st_q == K_OPEN);

  assert_open_after_key2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && !$past(unlocked_o)) |-> $past(key_wr_i && key_val_i == KEY_2));
  assert_consume_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !unlocked_o);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pe_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 40,
  parameter int unsigned ERASE_CYCLES = 400,
  parameter int unsigned WORD_AW      = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         op_i,
  input  logic [WORD_AW-1:0] word_i,
  input  logic [31:0]        data_i,
  input  logic               locked_i,
  output logic               busy_o,
  output logic               err_set_o,
  output logic               err_clr_o,
  output logic               prog_o,
  output logic               erase_o,
  output logic [WORD_AW-1:0] word_o,
  output logic [31:0]        data_o
);
  localparam int unsigned MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [3:0]         op_q;
  logic               lock_q, busy_q, done;
  logic [WORD_AW-1:0] word_q;
  logic [31:0]        data_q;

  function automatic logic [CNT_W-1:0] op_len(input logic [3:0] op);
    if (op == OP_PROG)       op_len = CNT_W'(PROG_CYCLES);
    else if (op == OP_ERASE) op_len = CNT_W'(ERASE_CYCLES);
    else                     op_len = CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      lock_q <= 1'b0;
      word_q <= '0;
      data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= op_len(op_i) - CNT_W'(1);
      op_q   <= op_i;
      lock_q <= locked_i;
      word_q <= word_i;
      data_q <= data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end

  assign done      = busy_q && (cnt_q == '0);
  assign busy_o    = busy_q;
  assign prog_o    = done && (op_q == OP_PROG) && !lock_q;
  assign erase_o   = done && (op_q == OP_ERASE) && !lock_q;
  assign err_set_o = done && (op_q == OP_PROG || op_q == OP_ERASE) && lock_q;
  assign err_clr_o = done && !(op_q == OP_PROG || op_q == OP_ERASE);
  assign word_o    = word_q;
  assign data_o    = data_q;

  // checker: busy window length
  int unsigned run_n;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              run_n <= 0;
    else if (start_i)         run_n <= 1;
    else if (busy_q && !done) run_n <= run_n + 1;

  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (run_n == int'(op_len(op_q))));
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_one_outcome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_o, erase_o, err_set_o, err_clr_o}));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int unsigned NUM_PAGES      = 8,
  parameter int unsigned WORDS_PER_PAGE = 16,
  parameter int unsigned WPP_AW         = 4,
  parameter int unsigned PAGE_AW        = 3,
  parameter int unsigned WORD_AW        = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prog_i,
  input  logic                 erase_i,
  input  logic [WORD_AW-1:0]   word_i,
  input  logic [31:0]          data_i,
  input  logic [NUM_PAGES-1:0] lock_i,
  input  logic [WORD_AW-1:0]   rd_word_i,
  output logic [31:0]          rdata_o
);
  localparam int unsigned WORDS = NUM_PAGES * WORDS_PER_PAGE;

  logic [31:0]        mem_q [WORDS];
  logic [PAGE_AW-1:0] page;

  assign page = word_i[WORD_AW-1 -: PAGE_AW];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [PAGE_AW-1:0] G_PAGE = PAGE_AW'(g / WORDS_PER_PAGE);
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                          mem_q[g] <= '1;
      else if (erase_i && page == G_PAGE)   mem_q[g] <= '1;
      else if (prog_i && word_i == WORD_AW'(g)) mem_q[g] <= mem_q[g] & data_i;
  end

  assign rdata_o = mem_q[rd_word_i];

  assert_locked_untouched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i || erase_i) |-> !lock_i[page]);
  assert_single_action_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_i && erase_i));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int unsigned NUM_PAGES      = 8,
  parameter int unsigned WORDS_PER_PAGE = 16,
  parameter int unsigned PROG_CYCLES    = 40,
  parameter int unsigned ERASE_CYCLES   = 400,
  localparam int unsigned WPP_AW        = $clog2(WORDS_PER_PAGE),
  localparam int unsigned PAGE_AW       = $clog2(NUM_PAGES),
  localparam int unsigned WORD_AW       = WPP_AW + PAGE_AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [1:0]           reg_acc_i,
  input  logic [31:0]          reg_wdata_i,
  input  logic [1:0]           reg_rd_sel_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_PAGES-1:0] page_lock_i,
  input  logic [WORD_AW-1:0]   arr_word_i,
  output logic [31:0]          arr_rdata_o,
  output logic                 busy_o
);
  logic [3:0]   op_q;
  logic         wren_q, wrerr_q, busy;
  logic [31:0]  addr_q, data_q, ctrl_cur, ctrl_new;
  logic         wr_live, ctrl_wr, key_wr, start, unlocked;
  logic         err_set, err_clr, a_prog, a_erase;
  logic [WORD_AW-1:0] a_word, tgt_word;
  logic [31:0]  a_data;

  assign wr_live  = reg_wr_i && (reg_acc_i != ACC_NONE);
  assign ctrl_wr  = wr_live && (reg_sel_i == SEL_CTRL) && !busy;
  assign key_wr   = wr_live && (reg_sel_i == SEL_KEY);

  always_comb begin
    ctrl_cur          = '0;
    ctrl_cur[3:0]     = op_q;
    ctrl_cur[B_WREN]  = wren_q;
    ctrl_cur[B_WRERR] = wrerr_q;
    ctrl_cur[B_BUSY]  = busy;
  end

  assign ctrl_new = acc_apply(reg_acc_i, ctrl_cur, reg_wdata_i);
  assign start    = ctrl_wr && ctrl_new[B_BUSY] && ctrl_new[B_WREN] && unlocked;
  assign tgt_word = addr_q[2 +: WORD_AW];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      op_q   <= OP_NOP;
      wren_q <= 1'b0;
    end else if (ctrl_wr) begin
      op_q   <= ctrl_new[3:0];
      wren_q <= ctrl_new[B_WREN];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      wrerr_q <= 1'b0;
    else if (err_set) wrerr_q <= 1'b1;
    else if (err_clr) wrerr_q <= 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (wr_live) begin
      if (reg_sel_i == SEL_ADDR) addr_q <= acc_apply(reg_acc_i, addr_q, reg_wdata_i);
      if (reg_sel_i == SEL_DATA) data_q <= acc_apply(reg_acc_i, data_q, reg_wdata_i);
    end

  flash_key_unlock i_key (
    .clk_i, .rst_ni,
    .key_wr_i   (key_wr),
    .key_val_i  (acc_apply(reg_acc_i, KEY_0, reg_wdata_i)),
    .consume_i  (ctrl_wr),
    .unlocked_o (unlocked)
  );

  flash_seq #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .WORD_AW(WORD_AW)
  ) i_seq (
    .clk_i, .rst_ni,
    .start_i   (start),
    .op_i      (ctrl_new[3:0]),
    .word_i    (tgt_word),
    .data_i    (data_q),
    .locked_i  (page_lock_i[tgt_word[WORD_AW-1 -: PAGE_AW]]),
    .busy_o    (busy),
    .err_set_o (err_set),
    .err_clr_o (err_clr),
    .prog_o    (a_prog),
    .erase_o   (a_erase),
    .word_o    (a_word),
    .data_o    (a_data)
  );

  flash_array #(
    .NUM_PAGES(NUM_PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE),
    .WPP_AW(WPP_AW), .PAGE_AW(PAGE_AW), .WORD_AW(WORD_AW)
  ) i_arr (
    .clk_i, .rst_ni,
    .prog_i    (a_prog),
    .erase_i   (a_erase),
    .word_i    (a_word),
    .data_i    (a_data),
    .lock_i    (page_lock_i),
    .rd_word_i (arr_word_i),
    .rdata_o   (arr_rdata_o)
  );

  always_comb
    case (reg_rd_sel_i)
      SEL_CTRL: reg_rdata_o = ctrl_cur;
      SEL_ADDR: reg_rdata_o = addr_q;
      SEL_DATA: reg_rdata_o = data_q;
      default:  reg_rdata_o = '0;
    endcase

  assign busy_o = busy;

  assert_start_needs_wren_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !$past(busy)) |-> (wren_q && $past(unlocked)));
  assert_busy_freezes_ctrl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(wren_q)));
  assert_err_only_hw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrerr_q) |-> $past(busy));
endmodule

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4, WPP = 4, PC = 3, EC = 7;
  localparam int WAW = 4;
  localparam logic [31:0] K0 = 32'h0, K1 = 32'hAA996655, K2 = 32'h556699AA;
  localparam logic [31:0] WREN = 32'h4000, WR = 32'h8000, ERR = 32'h2000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0, reg_acc = 0, rd_sel = 0;
  logic [31:0] wdata = 0, rdata, arr_rdata;
  logic [NP-1:0] lock = 0;
  logic [WAW-1:0] arr_word = 0;
  logic busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pe_ctrl #(.NUM_PAGES(NP), .WORDS_PER_PAGE(WPP), .PROG_CYCLES(PC), .ERASE_CYCLES(EC))
  i_flash_pe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_acc_i(reg_acc),
    .reg_wdata_i(wdata), .reg_rd_sel_i(rd_sel), .reg_rdata_o(rdata), .page_lock_i(lock),
    .arr_word_i(arr_word), .arr_rdata_o(arr_rdata), .busy_o(busy)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {bit is_arr; int idx; logic [31:0] exp; string tag;} item_t;
  item_t sb[$];
  int issued = 0, served = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations and compares against the read ports
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.is_arr) arr_word = WAW'(it.idx);
      else           rd_sel   = 2'(it.idx);
      #1;
      chk(it.tag, it.is_arr ? arr_rdata : rdata, it.exp);
      served++;
    end
  end

  task automatic expect_item(bit is_arr, int idx, logic [31:0] exp, string tag);
    item_t it;
    it.is_arr = is_arr; it.idx = idx; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    issued++;
    wait (served == issued);
  endtask

  task automatic exp_reg(int sel, logic [31:0] e, string tag); expect_item(0, sel, e, tag); endtask
  task automatic exp_arr(int w, logic [31:0] e, string tag);   expect_item(1, w, e, tag);   endtask

  task automatic wr(int sel, int acc, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = 2'(sel); reg_acc = 2'(acc); wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic unlock();
    wr(1, 0, K0); wr(1, 0, K1); wr(1, 0, K2);
  endtask

  task automatic go(output int n);
    wr(0, 1, WR);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic setup(int word, logic [31:0] d, logic [3:0] op);
    wr(2, 0, 32'(word * 4)); wr(3, 0, d); wr(0, 0, WREN | 32'(op));
  endtask

  int n;

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!finished) begin finished = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    exp_reg(0, 0, "R1 ctrl"); exp_reg(2, 0, "R1 addr"); exp_reg(3, 0, "R1 data");
    exp_reg(1, 0, "R1 key");
    chk("R1 busy", 32'(busy), 0);
    exp_arr(0, '1, "R1 arr first"); exp_arr(15, '1, "R1 arr last");

    // R2 access forms
    wr(2, 0, 32'hF0); wr(2, 1, 32'h03); exp_reg(2, 32'hF3, "R2 set");
    wr(2, 2, 32'h30); exp_reg(2, 32'hC3, "R2 clr");
    wr(2, 3, 32'hFFFF); exp_reg(2, 32'hC3, "R2 none");
    wr(3, 0, 32'h12345678); exp_reg(3, 32'h12345678, "R2 data raw");

    // R6 word program
    setup(5, 32'h12345678, 1); unlock(); go(n);
    chk("R6 busy len", 32'(n), PC);
    exp_arr(5, 32'h12345678, "R6 program");
    exp_reg(0, WREN | 1, "R10 busy cleared");
    wr(3, 0, 32'hFF00FF00); unlock(); go(n);
    exp_arr(5, 32'h12005600, "R6 and");

    // R3 key sequence
    go(n); chk("R3 no unlock", 32'(n), 0);
    exp_reg(0, WREN | 1, "R3 busy bit clear");
    wr(1, 0, K0); wr(1, 0, K1); wr(1, 0, 32'h1234); wr(1, 0, K2); go(n);
    chk("R3 broken seq", 32'(n), 0);
    exp_arr(5, 32'h12005600, "R3 array kept");
    wr(3, 0, 32'h0000FFFF);
    wr(1, 0, K0); wr(1, 0, K0); wr(1, 0, K1); wr(1, 0, K2); go(n);
    chk("R3 zero restarts", 32'(n), PC);
    exp_arr(5, 32'h00005600, "R3 restart program");

    // R5 unlock consumption
    unlock(); wr(0, 1, WREN); go(n); chk("R5 ctrl write consumes", 32'(n), 0);
    unlock(); go(n); go(n); chk("R5 start consumes", 32'(n), 0);

    // R7 page erase
    setup(3, 32'h0F0F0F0F, 1); unlock(); go(n);
    setup(8, 32'hA5A5A5A5, 1); unlock(); go(n);
    setup(6, 0, 4); unlock(); go(n);
    chk("R7 busy len", 32'(n), EC);
    exp_arr(4, '1, "R7 erased w4"); exp_arr(5, '1, "R7 erased w5"); exp_arr(7, '1, "R7 erased w7");
    exp_arr(3, 32'h0F0F0F0F, "R7 below kept"); exp_arr(8, 32'hA5A5A5A5, "R7 above kept");

    // R8 locked page
    lock = 4'b0100;
    setup(9, 0, 1); unlock(); go(n);
    chk("R8 busy len", 32'(n), PC);
    exp_arr(9, '1, "R8 prog blocked");
    exp_reg(0, WREN | ERR | 1, "R8 err flag");
    setup(8, 0, 4); unlock(); go(n);
    exp_arr(8, 32'hA5A5A5A5, "R8 erase blocked");
    wr(0, 0, WREN | 4); exp_reg(0, WREN | ERR | 4, "R9 err not writable");

    // R9 no-op recovery
    wr(0, 0, WREN); unlock(); go(n);
    chk("R9 nop len", 32'(n), 1);
    exp_reg(0, WREN, "R9 err cleared");
    lock = 0;

    // R10 writes while busy
    setup(12, 0, 1); unlock(); go(n);
    setup(13, 0, 4); unlock(); wr(0, 1, WR);
    wr(0, 0, 32'h1); wr(0, 2, WR | WREN);
    while (busy) @(negedge clk);
    exp_reg(0, WREN | 4, "R10 writes ignored");
    exp_arr(12, '1, "R10 erase done");

    // R4 write enable gate
    wr(0, 2, WREN); exp_reg(0, 4, "R4 wren cleared");
    wr(2, 0, 32'(12 * 4)); wr(0, 0, 1); unlock(); go(n);
    chk("R4 no wren", 32'(n), 0);
    exp_reg(0, 1, "R4 busy bit clear");
    exp_arr(12, '1, "R4 array kept");

    if (!finished) begin finished = 1; $display("CHECKS %0d ERRORS %0d", checks, errors); end
    $finish;
  end
endmodule